// File: doc/BRIEF.md
# Serial Receive Queue with Character Timeout

This block is the receive half of a classic FIFO-buffered UART. It oversamples an asynchronous serial line with 8 data bits, no parity and one stop bit (8N1). Each valid character goes into a 16-entry queue. A single interrupt line tells software that the queue needs service, and a 4-bit identification code gives the reason.

Two causes are tracked. The first is data-available: the fill level has reached a trigger level that software selects. The second is character timeout: one or more bytes have sat below the trigger level and nothing has been pushed or popped for four character times. The timeout makes sure that the tail of a message is still reported when that tail is shorter than the trigger level. One example is the last 5 bytes of a 13-byte burst with the trigger at 8.

A transmit-empty request from a neighbouring transmitter is merged into the same identification code at the lowest priority. Software pops bytes through a read strobe and receives each byte one cycle later.

Top module: `serial_rx_queue`

## Requirements
- R1: A frame is a low start bit, 8 data bits least-significant bit first, and a high stop bit, each bit lasting OVS*CLK_DIV clocks. Each received byte is returned by the read port in arrival order.
- R2: The start bit is accepted only if the line is still low half a bit period after the falling edge. A shorter low pulse produces no byte.
- R3: The queue holds 16 bytes. A byte that arrives while the queue is full is discarded and sets `overrun`. The next pop clears `overrun`. The 16 stored bytes are unaffected.
- R4: `trig_sel` encodes the trigger level: 0 gives 1 byte, 1 gives 4, 2 gives 8, and 3 gives 14. When the fill level is at or above the trigger level, `irq_id` becomes 0x4.
- R5: The data-available cause clears by itself once pops bring the fill level below the trigger level.
- R6: When the queue is not empty and neither a push nor a pop has happened for TO_CHARS*10 bit times (640 clocks by default), `irq_id` becomes 0xC. It does not appear well before that time. Any push or pop restarts the count, and an empty queue holds the count at zero.
- R7: The causes are ranked 0x4 (data available), then 0xC (timeout), then 0x2 (`tx_empty_req` high), then 0x1 (none pending). `irq` is high exactly when `irq_id` is not 0x1.
- R8: After reset, `irq_id` is 0x1 and `irq`, `data_ready` and `overrun` are all 0.
- R9: `rd_data` is registered. It holds the popped byte from the cycle after `rd_en` is sampled high.
- R10: `data_ready` is high exactly when the queue holds at least one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| trig_sel | input | 2 | Data-available trigger level select |
| rd_en | input | 1 | Pop one byte from the queue |
| tx_empty_req | input | 1 | Transmit-empty cause from the transmitter |
| rd_data | output | 8 | Most recently popped byte |
| data_ready | output | 1 | Queue is not empty |
| overrun | output | 1 | A byte was lost to a full queue |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Highest-priority pending cause code |

## Verification
The bench builds the block with its default values: CLK_DIV of 1, 16x oversampling and depth 16. With these values a character lasts 160 clocks and the timeout window is 640 clocks, so the whole state space is cheap to cover. Every burst length from 1 to 16 is swept against all four trigger levels. Each sweep checks the cause code before draining, after each pop, and on both sides of the timeout window. A 17-byte burst reaches the overrun path, and a short glitch tests start-bit validation.

// File: rtl/srq_pkg.sv
package srq_pkg;

  typedef enum logic [3:0] {
    ID_NONE = 4'h1,
    ID_TXE  = 4'h2,
    ID_RDA  = 4'h4,
    ID_CTI  = 4'hC
  } srq_id_e;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

endpackage

// File: rtl/srq_rx_sampler.sv
module srq_rx_sampler #(
  parameter int OVS     = 16,
  parameter int CLK_DIV = 1,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data
);

  localparam int OW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  logic              rx_s1, rx_s2;
  logic              tick;
  rx_state_e         state;
  logic [OW-1:0]     ocnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end
  end

  generate
    if (CLK_DIV == 1) begin : g_tick_always
      assign tick = 1'b1;
    end else begin : g_tick_div
      localparam int DW = $clog2(CLK_DIV);
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (rst) dcnt <= '0;
        else if (dcnt == DW'(CLK_DIV - 1)) dcnt <= '0;
        else dcnt <= dcnt + 1'b1;
      end
      assign tick = (dcnt == DW'(CLK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ocnt       <= '0;
      bitn       <= '0;
      shreg      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rx_s2) begin
              state <= S_START;
              ocnt  <= '0;
            end
          end
          S_START: begin
            if (ocnt == OW'(HALF - 1)) begin
              ocnt <= '0;
              bitn <= '0;
              state <= rx_s2 ? S_IDLE : S_DATA;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          S_DATA: begin
            if (ocnt == OW'(OVS - 1)) begin
              ocnt  <= '0;
              shreg <= {rx_s2, shreg[DATA_W-1:1]};
              if (bitn == BW'(DATA_W - 1)) state <= S_STOP;
              else bitn <= bitn + 1'b1;
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
          default: begin
            if (ocnt == OW'(OVS - 1)) begin
              ocnt  <= '0;
              state <= S_IDLE;
              if (rx_s2) begin
                byte_valid <= 1'b1;
                byte_data  <= shreg;
              end
            end else begin
              ocnt <= ocnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R2: a start bit that has returned high at mid-bit is abandoned
  p_false_start_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && state == S_START && ocnt == OW'(HALF - 1) && rx_s2) |=> state == S_IDLE);

  // R1: one push pulse per frame
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

endmodule

// File: rtl/srq_fifo.sv
module srq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [DATA_W-1:0]          din,
  input  logic                       pop,
  output logic [DATA_W-1:0]          dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full,
  output logic                       overrun
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (do_pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) overrun <= 1'b1;
      else if (do_pop)  overrun <= 1'b0;
    end
  end

  // R3: a byte lost to a full queue is flagged
  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> overrun);

  // R3: a full queue without a pop stays full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);

endmodule

// File: rtl/srq_char_timer.sv
module srq_char_timer #(
  parameter int LIMIT = 640
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic empty,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || empty || restart) cnt <= '0;
    else if (cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == TW'(LIMIT)) && !empty;

  // R6: activity always withdraws the timeout in the next cycle
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expired);

  // R6: an empty queue holds the count at zero
  p_empty_clear_r6: assert property (@(posedge clk) disable iff (rst)
    empty |=> cnt == '0);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue #(
  parameter int CLK_DIV  = 1,
  parameter int OVS      = 16,
  parameter int DEPTH    = 16,
  parameter int DATA_W   = 8,
  parameter int TO_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic [1:0]        trig_sel,
  input  logic              rd_en,
  input  logic              tx_empty_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_ready,
  output logic              overrun,
  output logic              irq,
  output logic [3:0]        irq_id
);
  import srq_pkg::*;

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int TO_CLKS    = TO_CHARS * FRAME_BITS * OVS * CLK_DIV;
  localparam int CW         = $clog2(DEPTH + 1);

  logic              byte_valid;
  logic [DATA_W-1:0] byte_data;
  logic [CW-1:0]     fill;
  logic              q_empty, q_full;
  logic              cti, rda;
  srq_id_e           id_next;

  srq_rx_sampler #(.OVS(OVS), .CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_sampler (
    .clk(clk), .rst(rst), .rxd(rxd),
    .byte_valid(byte_valid), .byte_data(byte_data)
  );

  srq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .push(byte_valid), .din(byte_data),
    .pop(rd_en), .dout(rd_data), .count(fill),
    .empty(q_empty), .full(q_full), .overrun(overrun)
  );

  srq_char_timer #(.LIMIT(TO_CLKS)) u_timer (
    .clk(clk), .rst(rst), .restart(byte_valid || rd_en),
    .empty(q_empty), .expired(cti)
  );

  assign data_ready = !q_empty;
  assign rda = (32'(fill) >= 32'(trig_level(trig_sel)));

  always_comb begin
    if (rda)               id_next = ID_RDA;
    else if (cti)          id_next = ID_CTI;
    else if (tx_empty_req) id_next = ID_TXE;
    else                   id_next = ID_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_id <= ID_NONE;
      irq    <= 1'b0;
    end else begin
      irq_id <= id_next;
      irq    <= (id_next != ID_NONE);
    end
  end

  // R4 / R7: a fill at the trigger wins over every other cause
  p_rda_priority_r7: assert property (@(posedge clk) disable iff (rst)
    (32'(fill) >= 32'(trig_level(trig_sel))) |=> irq_id == ID_RDA);

  // R7: with nothing stored and no transmit request, nothing is pending
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (q_empty && !tx_empty_req) |=> (irq_id == ID_NONE && !irq));

  // R6: timeout is never reported for an empty queue
  p_cti_has_data_r6: assert property (@(posedge clk) disable iff (rst)
    cti |-> !q_empty);

endmodule

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic       rd_en = 1'b0;
  logic       tx_empty_req = 1'b0;
  logic [7:0] rd_data;
  logic       data_ready, overrun, irq;
  logic [3:0] irq_id;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  serial_rx_queue u_dut (
    .clk(clk), .rst(rst), .rxd(rxd), .trig_sel(trig_sel), .rd_en(rd_en),
    .tx_empty_req(tx_empty_req), .rd_data(rd_data), .data_ready(data_ready),
    .overrun(overrun), .irq(irq), .irq_id(irq_id)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = fr[i];
      repeat (16) @(negedge clk);
    end
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    d = rd_data;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int n, input int k, input int t);
    return 8'(n * 17 + k * 29 + t * 5 + 3);
  endfunction

  initial begin
    logic [7:0] d;
    int lvl;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check(irq_id == 4'h1, "R8 irq_id", irq_id, 1);
    check(!irq && !data_ready && !overrun, "R8 flags", {irq, data_ready, overrun}, 0);

    // R2: glitch shorter than half a bit
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    check(!data_ready, "R2 glitch ignored", data_ready, 0);

    // sweep of trigger level and burst length
    for (int t = 0; t < 4; t++) begin
      trig_sel = 2'(t);
      lvl = (t == 0) ? 1 : (t == 1) ? 4 : (t == 2) ? 8 : 14;
      for (int n = 1; n <= 16; n++) begin
        for (int k = 0; k < n; k++) send_byte(pat(n, k, t));
        repeat (20) @(negedge clk);
        check(data_ready, "R10 ready", data_ready, 1);
        if (n >= lvl) begin
          check(irq_id == 4'h4 && irq, "R4 rda", irq_id, 4);
        end else begin
          repeat (380) @(negedge clk);
          check(irq_id == 4'h1 && !irq, "R6 not early", irq_id, 1);
          repeat (520) @(negedge clk);
          check(irq_id == 4'hC && irq, "R6 timeout", irq_id, 12);
        end
        for (int k = 0; k < n; k++) begin
          pop(d);
          check(d == pat(n, k, t), "R1 R9 data", d, pat(n, k, t));
          check(irq_id == ((n - k - 1 >= lvl) ? 4'h4 : 4'h1), "R5 after pop",
                irq_id, (n - k - 1 >= lvl) ? 4 : 1);
        end
        check(!data_ready, "R10 drained", data_ready, 0);
      end
    end

    // R3 overrun
    trig_sel = 2'd3;
    for (int k = 0; k < 17; k++) send_byte(pat(99, k, 7));
    repeat (20) @(negedge clk);
    check(overrun, "R3 overrun set", overrun, 1);
    for (int k = 0; k < 16; k++) begin
      pop(d);
      check(d == pat(99, k, 7), "R3 kept data", d, pat(99, k, 7));
      if (k == 0) check(!overrun, "R3 overrun cleared", overrun, 0);
    end
    check(!data_ready, "R3 only 16 stored", data_ready, 0);

    // R7 priority
    tx_empty_req = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_id == 4'h2 && irq, "R7 txe", irq_id, 2);
    send_byte(8'h5A);
    repeat (20) @(negedge clk);
    check(irq_id == 4'h2, "R7 txe below trig", irq_id, 2);
    repeat (900) @(negedge clk);
    check(irq_id == 4'hC, "R7 cti over txe", irq_id, 12);
    trig_sel = 2'd0;
    repeat (3) @(negedge clk);
    check(irq_id == 4'h4, "R7 rda over all", irq_id, 4);
    pop(d);
    check(irq_id == 4'h2, "R7 txe after drain", irq_id, 2);
    tx_empty_req = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_id == 4'h1 && !irq, "R7 none", irq_id, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (195000) @(negedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R8 watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule